// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block is the shared datapath for rotate-then-mask integer operations. It receives a 64-bit operand, a 6-bit left-rotate amount, a word-size select and a pair of mask bounds. It returns two values: the operand rotated left, and a contiguous bit mask built from the bounds. Downstream logic combines the two, either with an AND or with an insert into a destination, and that combining step is not part of this block. The block has no state. Both outputs follow the inputs combinationally.

Mask bounds count bits from the most significant end: position 0 is bit 63 in little-endian terms, and position 63 is bit 0. When the first bound is at or before the last bound, the mask covers that inclusive range. When the first bound is after the last bound, the mask wraps around: it covers both ends of the word and leaves the middle clear.

In 32-bit mode the low word is copied into both halves before the 64-bit rotate, so either half of the result holds the 32-bit rotation. The bounds are then read as word positions 0 to 31 and moved by 32 so that they fall in the low word.

Top module: `rotmask_unit`

## Requirements
- R1: In 64-bit mode (word32_i=0), rot_o equals operand_i rotated left by amount_i positions (mod 64). Rotating 0xdeadbeef12345678 by 10 gives 0xb6fbbc48d159e37a, and by 35 gives 0x91a2b3c6f56df778.
- R2: An amount of 0 in 64-bit mode returns operand_i unchanged.
- R3: In 32-bit mode (word32_i=1), operand_i[63:32] is ignored. rot_o is the 64-bit left rotate by amount_i of {operand_i[31:0], operand_i[31:0]}, so both halves of rot_o are equal.
- R4: In 64-bit mode with first_i <= last_i, mask_o sets the bits at MSB-0 positions first_i through last_i inclusive and clears every other bit. MSB-0 position p is mask_o bit 63-p. For example, (37,63) gives 0x7ffffff and (0,10) gives 0xffe0000000000000.
- R5: In 64-bit mode with first_i > last_i, mask_o sets positions 0..last_i and first_i..63 and clears the gap between them. For example, (47,37) gives 0xfffffffffc01ffff.
- R6: When the effective bounds are equal, mask_o has exactly one bit set, at that position. For example, (32,32) gives 0x80000000.
- R7: In 32-bit mode, only bits [4:0] of each bound are used, and 32 is added to each. A non-wrapping mask therefore leaves mask_o[63:32] clear. For example, word bounds (5,15) give 0x7ff0000, and (30,2) give 0xffffffffe0000003.
- R8: Both outputs are combinational. A change on any input reaches rot_o and mask_o with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 64 | Value to rotate |
| amount_i | input | 6 | Left-rotate amount |
| word32_i | input | 1 | 1 selects 32-bit mode |
| first_i | input | 6 | Mask start position (MSB-0) |
| last_i | input | 6 | Mask end position (MSB-0) |
| rot_o | output | 64 | Rotated operand |
| mask_o | output | 64 | Generated mask |

## Verification
The known-answer rotate vectors catch bit-order and stage-swap errors in the rotator. Amount 0 and amount 63 test the ends of the range. Masks are tried with ordered bounds, swapped bounds, equal bounds and the extreme bounds 0 and 63. These cases separate a correct wrap decision from an off-by-one error at either end. In 32-bit mode, junk is placed in the upper operand bits and in bound bit 5, which shows that the replicate and offset steps really discard those bits. Random sweeps in both modes are compared against a bitwise reference model in the bench.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned POS_W  = $clog2(DATA_W);
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [POS_W-1:0]  pos_t;
endpackage

// File: rtl/rotm_word_prep.sv
module rotm_word_prep #(
  parameter int unsigned W  = 64,
  parameter int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  operand_i,
  input  logic          word32_i,
  input  logic [PW-1:0] first_i,
  input  logic [PW-1:0] last_i,
  output logic [W-1:0]  operand_o,
  output logic [PW-1:0] first_o,
  output logic [PW-1:0] last_o
);
  localparam int unsigned HW = W / 2;

  // half-word mode: duplicate low half, bounds land in low half (+HW)
  always_comb begin
    if (word32_i) begin
      operand_o = {operand_i[HW-1:0], operand_i[HW-1:0]};
      first_o   = {1'b1, first_i[PW-2:0]};
      last_o    = {1'b1, last_i[PW-2:0]};
    end else begin
      operand_o = operand_i;
      first_o   = first_i;
      last_o    = last_i;
    end
  end
endmodule

// File: rtl/rotm_rotator.sv
module rotm_rotator #(
  parameter int unsigned W  = 64,
  parameter int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [PW-1:0] amount_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [PW+1];

  assign stage[0] = data_i;

  // log-depth barrel, stage s rotates by 2**s
  for (genvar s = 0; s < PW; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    logic [W-1:0] rotated;
    assign rotated      = {stage[s][W-1-SH:0], stage[s][W-1:W-SH]};
    assign stage[s+1]   = amount_i[s] ? rotated : stage[s];
  end

  assign data_o = stage[PW];
endmodule

// File: rtl/rotm_mask_gen.sv
module rotm_mask_gen #(
  parameter int unsigned W  = 64,
  parameter int unsigned PW = $clog2(W)
) (
  input  logic [PW-1:0] first_i,
  input  logic [PW-1:0] last_i,
  output logic [W-1:0]  mask_o
);
  logic wrap;
  assign wrap = first_i > last_i;

  // per-bit compare against MSB-0 position of that bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [PW-1:0] POS = PW'(W - 1 - i);
    logic after_first, before_last;
    assign after_first = POS >= first_i;
    assign before_last = POS <= last_i;
    assign mask_o[i]   = wrap ? (after_first | before_last)
                              : (after_first & before_last);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
(
  input  logic [63:0] operand_i,
  input  logic [5:0]  amount_i,
  input  logic        word32_i,
  input  logic [5:0]  first_i,
  input  logic [5:0]  last_i,
  output logic [63:0] rot_o,
  output logic [63:0] mask_o
);
  data_t prep_op;
  pos_t  prep_first, prep_last;

  rotm_word_prep #(.W(DATA_W), .PW(POS_W)) u_prep (
    .operand_i (operand_i),
    .word32_i  (word32_i),
    .first_i   (first_i),
    .last_i    (last_i),
    .operand_o (prep_op),
    .first_o   (prep_first),
    .last_o    (prep_last)
  );

  rotm_rotator #(.W(DATA_W), .PW(POS_W)) u_rot (
    .data_i   (prep_op),
    .amount_i (amount_i),
    .data_o   (rot_o)
  );

  rotm_mask_gen #(.W(DATA_W), .PW(POS_W)) u_mask (
    .first_i (prep_first),
    .last_i  (prep_last),
    .mask_o  (mask_o)
  );
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk (
  input logic [63:0] operand_i,
  input logic [5:0]  amount_i,
  input logic        word32_i,
  input logic [5:0]  first_i,
  input logic [5:0]  last_i,
  input logic [63:0] rot_o,
  input logic [63:0] mask_o
);
  always_comb begin
    // R2
    if (!word32_i && amount_i == 6'd0) begin
      rot_zero_chk: assert (rot_o == operand_i);
    end
    // R3
    if (word32_i) begin
      half_dup_chk: assert (rot_o[63:32] == rot_o[31:0]);
    end
    // R6
    if (word32_i ? (first_i[4:0] == last_i[4:0]) : (first_i == last_i)) begin
      single_bit_chk: assert ($countones(mask_o) == 1);
    end
    // R4
    if (!word32_i && first_i <= last_i) begin
      range_len_chk: assert ($countones(mask_o) == int'(last_i) - int'(first_i) + 1);
    end
    // R5
    if (!word32_i && first_i > last_i) begin
      wrap_len_chk: assert ($countones(mask_o) == 65 - int'(first_i) + int'(last_i));
    end
    // R7
    if (word32_i && first_i[4:0] <= last_i[4:0]) begin
      low_word_chk: assert (mask_o[63:32] == 32'd0);
    end
  end
endmodule

bind rotmask_unit rotmask_unit_chk u_chk (
  .operand_i (operand_i),
  .amount_i  (amount_i),
  .word32_i  (word32_i),
  .first_i   (first_i),
  .last_i    (last_i),
  .rot_o     (rot_o),
  .mask_o    (mask_o)
);

// File: tb/rotmask_unit_test.sv
module rotmask_unit_test;
  logic        clk = 1'b0;
  logic [63:0] operand_i = '0;
  logic [5:0]  amount_i = '0;
  logic        word32_i = 1'b0;
  logic [5:0]  first_i = '0;
  logic [5:0]  last_i = '0;
  logic [63:0] rot_o, mask_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rotmask_unit uut (.*);

  function automatic logic [63:0] ref_rot(logic [63:0] v, int n);
    logic [63:0] r = v;
    for (int k = 0; k < n; k++) r = {r[62:0], r[63]};
    return r;
  endfunction

  function automatic logic [63:0] ref_mask(int s, int e);
    logic [63:0] m = '0;
    for (int p = 0; p < 64; p++)
      m[63-p] = (s <= e) ? (p >= s && p <= e) : (p >= s || p <= e);
    return m;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] v, int n, bit w32, int s, int e);
    @(negedge clk);
    operand_i = v; amount_i = 6'(n); word32_i = w32;
    first_i = 6'(s); last_i = 6'(e);
    #1;
  endtask

  task automatic t_zero_inputs;
    drive(64'h0, 0, 0, 0, 0);
    check("R6 zero rot", rot_o, 64'h0);
    check("R6 zero mask", mask_o, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_rot64_vectors;
    drive(64'hdeadbeef12345678, 10, 0, 0, 63);
    check("R1 rot10", rot_o, 64'hb6fbbc48d159e37a);
    drive(64'hdeadbeef12345678, 35, 0, 0, 63);
    check("R1 rot35", rot_o, 64'h91a2b3c6f56df778);
    drive(64'hdeadbeef12345678, 58, 0, 0, 63);
    check("R1 rot58", rot_o, 64'he37ab6fbbc48d159);
    drive(64'h8000_0000_0000_0001, 63, 0, 0, 63);
    check("R1 rot63", rot_o, 64'hc000_0000_0000_0000);
  endtask

  task automatic t_rot_zero;
    drive(64'hdeadbeef12345678, 0, 0, 5, 9);
    check("R2 amount0", rot_o, 64'hdeadbeef12345678);
  endtask

  task automatic t_rot32;
    drive(64'h1234_5678_dead_beef, 10, 1, 0, 31);
    check("R3 rot32 by10", rot_o[31:0], 32'hb6fbbf7a);
    check("R3 halves equal", rot_o, {2{32'hb6fbbf7a}});
    drive(64'hffff_ffff_dead_beef, 17, 1, 0, 31);
    check("R3 high ignored", rot_o, {2{32'h7ddfbd5b}});
  endtask

  task automatic t_mask_range;
    drive(64'h0, 0, 0, 37, 63);
    check("R4 37..63", mask_o, 64'h7ffffff);
    drive(64'h0, 0, 0, 0, 10);
    check("R4 0..10", mask_o, 64'hffe0000000000000);
    drive(64'h0, 0, 0, 0, 63);
    check("R4 full", mask_o, 64'hffff_ffff_ffff_ffff);
  endtask

  task automatic t_mask_wrap;
    drive(64'h0, 0, 0, 47, 37);
    check("R5 wrap 47,37", mask_o, 64'hfffffffffc01ffff);
    drive(64'h0, 0, 0, 63, 0);
    check("R5 wrap 63,0", mask_o, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_mask_single;
    drive(64'h0, 0, 0, 32, 32);
    check("R6 32,32", mask_o, 64'h80000000);
    drive(64'h0, 0, 0, 33, 33);
    check("R6 33,33", mask_o, 64'h40000000);
    drive(64'h0, 0, 0, 63, 63);
    check("R6 63,63", mask_o, 64'h1);
  endtask

  task automatic t_mask32;
    drive(64'h0, 0, 1, 5, 15);
    check("R7 5,15", mask_o, 64'h7ff0000);
    drive(64'h0, 0, 1, 6'h20 | 30, 6'h20 | 2);
    check("R7 wrap bit5 junk", mask_o, 64'hffffffffe0000003);
    drive(64'h0, 0, 1, 0, 0);
    check("R7 0,0", mask_o, 64'h80000000);
  endtask

  task automatic t_comb;
    @(negedge clk);
    operand_i = 64'h1; amount_i = 6'd4; word32_i = 0; first_i = 6'd60; last_i = 6'd61;
    #0.5;
    check("R8 rot no edge", rot_o, 64'h10);
    check("R8 mask no edge", mask_o, 64'hc);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] v = {$urandom, $urandom};
      int n = $urandom_range(0, 63);
      int s = $urandom_range(0, 63);
      int e = $urandom_range(0, 63);
      bit w = k[0];
      drive(v, n, w, s, e);
      if (w) begin
        check("R3 rand rot", rot_o, ref_rot({v[31:0], v[31:0]}, n));
        check("R7 rand mask", mask_o, ref_mask(32 + s % 32, 32 + e % 32));
      end else begin
        check("R1 rand rot", rot_o, ref_rot(v, n));
        check(s > e ? "R5 rand mask" : "R4 rand mask", mask_o, ref_mask(s, e));
      end
    end
  endtask

  initial begin
    t_zero_inputs();
    t_rot64_vectors();
    t_rot_zero();
    t_rot32();
    t_mask_range();
    t_mask_wrap();
    t_mask_single();
    t_mask32();
    t_comb();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule